// File: doc/BRIEF.md
# Blocking Two-Port Memory Forwarder

This block joins a processor's instruction request port and data request port to one downstream memory port. It takes at most one request at a time, passes it to memory, and when memory answers it sends the answer back to whichever upstream side asked. Address, command, data and an instruction-fetch tag travel through unchanged. The block reads only the tag, and only to choose the return port.

Every link in both directions uses the same handshake. A sender raises a valid strobe, and the receiver accepts or refuses it in that same cycle. After a refusal the sender keeps its item and may offer it again only after the receiver sends a one-cycle retry pulse. The receiver never stores a refused item. It only records that it owes a retry, and it sends the pulse in a cycle where it can take a new item at once. The block plays the receiver toward both upstream ports and toward memory responses. It plays the sender toward memory requests and toward upstream responses.

Top module: `blk_mem_fwd`

## Requirements
- R1: After reset, every valid, accept and retry output is low and the block is idle.
- R2: While idle, a request offered on an upstream port is accepted (accept high) in the same cycle. In the next cycle it appears on the memory request port with address, command, data and tag unchanged. Memory request valid goes low in the cycle after memory accepts it.
- R3: From the cycle a request is accepted until memory's response to it is accepted, every upstream request is refused (accept low) in the cycle it is offered.
- R4: If both upstream ports offer in the same idle cycle, the instruction port is accepted and the data port is refused.
- R5: If memory refuses the forwarded request, memory request valid goes low from the next cycle. It stays low until a memory request retry pulse. The same request is then offered again in the cycle after that pulse. Loading the held slot while it is occupied is an error.
- R6: A memory response is accepted in the cycle it is offered when the block is busy and the target port holds no response. Tag value 1 targets the instruction port and tag value 0 targets the data port. The response is presented on the target port in the next cycle, and in that cycle the block is idle and accepts a new request.
- R7: If an upstream port refuses a response, that port's response valid goes low from the next cycle until the port's response retry pulse. The same response is offered again in the cycle after that pulse.
- R8: A port whose request was refused is owed a retry. It receives exactly one single-cycle request retry pulse, and only in a cycle where it holds no undelivered response. A port that was never refused receives none.
- R9: A request retry pulse occurs only while the block is idle and no upstream request is offered, and to at most one port per cycle, with the instruction port first.
- R10: A memory response aimed at a port that still holds an undelivered response is refused. Once both ports hold nothing, the block pulses the memory response retry for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ip_req_vld | input | 1 | Instruction-side request valid |
| ip_req_addr | input | FWD_ADDR_W | Instruction-side request address |
| ip_req_cmd | input | FWD_CMD_W | Instruction-side request command |
| ip_req_data | input | FWD_DATA_W | Instruction-side request data |
| ip_req_ifetch | input | 1 | Instruction-side request fetch tag |
| ip_req_acc | output | 1 | Instruction-side request accepted this cycle |
| ip_req_retry | output | 1 | Instruction-side request retry pulse |
| ip_rsp_vld | output | 1 | Instruction-side response valid |
| ip_rsp_addr | output | FWD_ADDR_W | Instruction-side response address |
| ip_rsp_cmd | output | FWD_CMD_W | Instruction-side response command |
| ip_rsp_data | output | FWD_DATA_W | Instruction-side response data |
| ip_rsp_ifetch | output | 1 | Instruction-side response fetch tag |
| ip_rsp_acc | input | 1 | Instruction side takes the response this cycle |
| ip_rsp_retry | input | 1 | Instruction side response retry pulse |
| dp_req_vld | input | 1 | Data-side request valid |
| dp_req_addr | input | FWD_ADDR_W | Data-side request address |
| dp_req_cmd | input | FWD_CMD_W | Data-side request command |
| dp_req_data | input | FWD_DATA_W | Data-side request data |
| dp_req_ifetch | input | 1 | Data-side request fetch tag |
| dp_req_acc | output | 1 | Data-side request accepted this cycle |
| dp_req_retry | output | 1 | Data-side request retry pulse |
| dp_rsp_vld | output | 1 | Data-side response valid |
| dp_rsp_addr | output | FWD_ADDR_W | Data-side response address |
| dp_rsp_cmd | output | FWD_CMD_W | Data-side response command |
| dp_rsp_data | output | FWD_DATA_W | Data-side response data |
| dp_rsp_ifetch | output | 1 | Data-side response fetch tag |
| dp_rsp_acc | input | 1 | Data side takes the response this cycle |
| dp_rsp_retry | input | 1 | Data side response retry pulse |
| mp_req_vld | output | 1 | Memory request valid |
| mp_req_addr | output | FWD_ADDR_W | Memory request address |
| mp_req_cmd | output | FWD_CMD_W | Memory request command |
| mp_req_data | output | FWD_DATA_W | Memory request data |
| mp_req_ifetch | output | 1 | Memory request fetch tag |
| mp_req_acc | input | 1 | Memory takes the request this cycle |
| mp_req_retry | input | 1 | Memory request retry pulse |
| mp_rsp_vld | input | 1 | Memory response valid |
| mp_rsp_addr | input | FWD_ADDR_W | Memory response address |
| mp_rsp_cmd | input | FWD_CMD_W | Memory response command |
| mp_rsp_data | input | FWD_DATA_W | Memory response data |
| mp_rsp_ifetch | input | 1 | Memory response fetch tag, selects return port |
| mp_rsp_acc | output | 1 | Memory response accepted this cycle |
| mp_rsp_retry | output | 1 | Memory response retry pulse |

## Verification
The hardest case to reach is a memory response aimed at a port that still holds an undelivered earlier response. Only that case drives the memory-response refusal and its later retry. The bench builds it in steps. First it refuses a data-side response. While that response is still held, it issues a fresh data request and has memory answer it. Then it releases the held response and watches for the memory retry. A related sequence keeps the data port owed a retry while it also holds a response. It checks that the retry is withheld until the held response drains.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    parameter int unsigned FWD_ADDR_W   = 32;
    parameter int unsigned FWD_DATA_W   = 32;
    parameter int unsigned FWD_CMD_W    = 2;
    parameter int unsigned FWD_UP_PORTS = 2;   // index 0: instruction, 1: data

    typedef struct packed {
        logic                  ifetch;
        logic [FWD_CMD_W-1:0]  cmd;
        logic [FWD_ADDR_W-1:0] addr;
        logic [FWD_DATA_W-1:0] data;
    } fwd_pkt_t;

    localparam int unsigned FWD_PKT_W = $bits(fwd_pkt_t);

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_SEND  = 2'd1,
        SLOT_HOLD  = 2'd2
    } slot_st_e;

    // Upstream port a response returns to: fetches to port 0, others to port 1.
    function automatic logic route_port(input fwd_pkt_t p);
        return p.ifetch ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/fwd_hold_slot.sv
module fwd_hold_slot
    import fwd_pkg::*;
#(
    parameter int unsigned W = FWD_PKT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_pkt,
    output logic         out_vld,
    output logic [W-1:0] out_pkt,
    input  logic         peer_acc,
    input  logic         peer_retry,
    output logic         empty
);

    slot_st_e     st_q, st_d;
    logic [W-1:0] pkt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_EMPTY: if (load)       st_d = SLOT_SEND;
            SLOT_SEND:  st_d = peer_acc ? SLOT_EMPTY : SLOT_HOLD;
            SLOT_HOLD:  if (peer_retry) st_d = SLOT_SEND;
            default:    st_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SLOT_EMPTY;
            pkt_q <= '0;
        end else begin
            st_q <= st_d;
            if (load && st_q == SLOT_EMPTY) pkt_q <= load_pkt;
        end
    end

    assign out_vld = (st_q == SLOT_SEND);
    assign out_pkt = pkt_q;
    assign empty   = (st_q == SLOT_EMPTY);

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        load |-> empty);                                                   // R5
    AST_REFUSED_WITHDRAWS: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !peer_acc) |=> !out_vld);                              // R5
    AST_WAIT_FOR_RETRY: assert property (@(posedge clk) disable iff (rst)
        (st_q == SLOT_HOLD && !peer_retry) |=> !out_vld);                  // R7
    AST_RESEND_SAME: assert property (@(posedge clk) disable iff (rst)
        (st_q == SLOT_HOLD && peer_retry) |=> (out_vld && $stable(out_pkt))); // R5

endmodule

// File: rtl/fwd_retry_owe.sv
module fwd_retry_owe (
    input  logic clk,
    input  logic rst,
    input  logic refuse,
    input  logic allow,
    output logic retry,
    output logic owed
);

    logic owe_q;

    always_ff @(posedge clk) begin
        if (rst) owe_q <= 1'b0;
        else     owe_q <= (owe_q & ~allow) | refuse;
    end

    assign owed  = owe_q;
    assign retry = owe_q & allow;

    AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (retry && !refuse) |=> !retry);                                    // R8
    AST_RETRY_NEEDS_REFUSAL: assert property (@(posedge clk) disable iff (rst)
        $rose(owe_q) |-> $past(refuse));                                   // R8

endmodule

// File: rtl/blk_mem_fwd.sv
module blk_mem_fwd
    import fwd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ip_req_vld,
    input  logic [FWD_ADDR_W-1:0] ip_req_addr,
    input  logic [FWD_CMD_W-1:0]  ip_req_cmd,
    input  logic [FWD_DATA_W-1:0] ip_req_data,
    input  logic                  ip_req_ifetch,
    output logic                  ip_req_acc,
    output logic                  ip_req_retry,
    output logic                  ip_rsp_vld,
    output logic [FWD_ADDR_W-1:0] ip_rsp_addr,
    output logic [FWD_CMD_W-1:0]  ip_rsp_cmd,
    output logic [FWD_DATA_W-1:0] ip_rsp_data,
    output logic                  ip_rsp_ifetch,
    input  logic                  ip_rsp_acc,
    input  logic                  ip_rsp_retry,
    input  logic                  dp_req_vld,
    input  logic [FWD_ADDR_W-1:0] dp_req_addr,
    input  logic [FWD_CMD_W-1:0]  dp_req_cmd,
    input  logic [FWD_DATA_W-1:0] dp_req_data,
    input  logic                  dp_req_ifetch,
    output logic                  dp_req_acc,
    output logic                  dp_req_retry,
    output logic                  dp_rsp_vld,
    output logic [FWD_ADDR_W-1:0] dp_rsp_addr,
    output logic [FWD_CMD_W-1:0]  dp_rsp_cmd,
    output logic [FWD_DATA_W-1:0] dp_rsp_data,
    output logic                  dp_rsp_ifetch,
    input  logic                  dp_rsp_acc,
    input  logic                  dp_rsp_retry,
    output logic                  mp_req_vld,
    output logic [FWD_ADDR_W-1:0] mp_req_addr,
    output logic [FWD_CMD_W-1:0]  mp_req_cmd,
    output logic [FWD_DATA_W-1:0] mp_req_data,
    output logic                  mp_req_ifetch,
    input  logic                  mp_req_acc,
    input  logic                  mp_req_retry,
    input  logic                  mp_rsp_vld,
    input  logic [FWD_ADDR_W-1:0] mp_rsp_addr,
    input  logic [FWD_CMD_W-1:0]  mp_rsp_cmd,
    input  logic [FWD_DATA_W-1:0] mp_rsp_data,
    input  logic                  mp_rsp_ifetch,
    output logic                  mp_rsp_acc,
    output logic                  mp_rsp_retry
);

    localparam int unsigned NUP = FWD_UP_PORTS;

    logic           busy_q;
    fwd_pkt_t       up_req [NUP];
    fwd_pkt_t       up_rsp [NUP];
    logic [NUP-1:0] up_vld, up_acc, up_refuse, up_allow, up_retry, up_owed;
    logic [NUP-1:0] slot_empty, slot_load, rsp_vld, rsp_acc, rsp_retry;
    fwd_pkt_t       fwd_pkt, dn_pkt, mem_rsp_pkt;
    logic           arb_claim, retry_claim;
    logic           dn_load, dn_empty, rsp_take, rsp_tgt, mem_owed;

    // Upstream port mapping
    assign up_req[0] = '{ifetch: ip_req_ifetch, cmd: ip_req_cmd, addr: ip_req_addr, data: ip_req_data};
    assign up_req[1] = '{ifetch: dp_req_ifetch, cmd: dp_req_cmd, addr: dp_req_addr, data: dp_req_data};
    assign up_vld    = {dp_req_vld, ip_req_vld};
    assign rsp_acc   = {dp_rsp_acc, ip_rsp_acc};
    assign rsp_retry = {dp_rsp_retry, ip_rsp_retry};

    assign ip_req_acc    = up_acc[0];
    assign dp_req_acc    = up_acc[1];
    assign ip_req_retry  = up_retry[0];
    assign dp_req_retry  = up_retry[1];
    assign ip_rsp_vld    = rsp_vld[0];
    assign dp_rsp_vld    = rsp_vld[1];
    assign ip_rsp_addr   = up_rsp[0].addr;
    assign ip_rsp_cmd    = up_rsp[0].cmd;
    assign ip_rsp_data   = up_rsp[0].data;
    assign ip_rsp_ifetch = up_rsp[0].ifetch;
    assign dp_rsp_addr   = up_rsp[1].addr;
    assign dp_rsp_cmd    = up_rsp[1].cmd;
    assign dp_rsp_data   = up_rsp[1].data;
    assign dp_rsp_ifetch = up_rsp[1].ifetch;

    // Request acceptance: fixed priority, lowest index first, only while idle
    always_comb begin
        arb_claim = busy_q;
        fwd_pkt   = up_req[0];
        for (int k = 0; k < NUP; k++) begin
            up_acc[k] = up_vld[k] & ~arb_claim;
            if (up_acc[k]) fwd_pkt = up_req[k];
            arb_claim = arb_claim | up_vld[k];
        end
    end

    assign up_refuse = up_vld & ~up_acc;
    assign dn_load   = |up_acc;

    // Request retry: only when a new request could be taken right now
    always_comb begin
        retry_claim = busy_q | (|up_vld);
        for (int k = 0; k < NUP; k++) begin
            up_allow[k] = ~retry_claim & slot_empty[k];
            retry_claim = retry_claim | (up_owed[k] & slot_empty[k]);
        end
    end

    // Memory response routing
    assign mem_rsp_pkt = '{ifetch: mp_rsp_ifetch, cmd: mp_rsp_cmd, addr: mp_rsp_addr, data: mp_rsp_data};
    assign rsp_tgt     = route_port(mem_rsp_pkt);
    assign rsp_take    = mp_rsp_vld & busy_q & slot_empty[rsp_tgt];
    assign mp_rsp_acc  = rsp_take;

    // Busy is dropped at the response hand-off edge, before upstream delivery
    always_ff @(posedge clk) begin
        if (rst)           busy_q <= 1'b0;
        else if (dn_load)  busy_q <= 1'b1;
        else if (rsp_take) busy_q <= 1'b0;
    end

    fwd_hold_slot #(.W(FWD_PKT_W)) u_dn_slot (
        .clk        (clk),
        .rst        (rst),
        .load       (dn_load),
        .load_pkt   (fwd_pkt),
        .out_vld    (mp_req_vld),
        .out_pkt    (dn_pkt),
        .peer_acc   (mp_req_acc),
        .peer_retry (mp_req_retry),
        .empty      (dn_empty)
    );

    assign mp_req_addr   = dn_pkt.addr;
    assign mp_req_cmd    = dn_pkt.cmd;
    assign mp_req_data   = dn_pkt.data;
    assign mp_req_ifetch = dn_pkt.ifetch;

    for (genvar g = 0; g < NUP; g++) begin : g_up
        assign slot_load[g] = rsp_take && (int'(rsp_tgt) == g);

        fwd_hold_slot #(.W(FWD_PKT_W)) u_rsp_slot (
            .clk        (clk),
            .rst        (rst),
            .load       (slot_load[g]),
            .load_pkt   (mem_rsp_pkt),
            .out_vld    (rsp_vld[g]),
            .out_pkt    (up_rsp[g]),
            .peer_acc   (rsp_acc[g]),
            .peer_retry (rsp_retry[g]),
            .empty      (slot_empty[g])
        );

        fwd_retry_owe u_owe (
            .clk    (clk),
            .rst    (rst),
            .refuse (up_refuse[g]),
            .allow  (up_allow[g]),
            .retry  (up_retry[g]),
            .owed   (up_owed[g])
        );

        AST_RETRY_NOT_HOLDING: assert property (@(posedge clk) disable iff (rst)
            up_retry[g] |-> !rsp_vld[g]);                                  // R8
    end

    fwd_retry_owe u_mem_owe (
        .clk    (clk),
        .rst    (rst),
        .refuse (mp_rsp_vld & ~rsp_take),
        .allow  (&slot_empty),
        .retry  (mp_rsp_retry),
        .owed   (mem_owed)
    );

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(up_acc));                                                 // R4
    AST_DN_FREE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        dn_load |-> dn_empty);                                             // R3
    AST_FORWARD_NEXT: assert property (@(posedge clk) disable iff (rst)
        dn_load |=> mp_req_vld);                                           // R2
    AST_RSP_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
        rsp_take |=> (ip_rsp_vld ^ dp_rsp_vld));                           // R6
    AST_RETRY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (|up_retry) |-> (!busy_q && $countones(up_retry) == 1 && up_vld == '0)); // R9
    AST_MEM_OWE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_owed |-> busy_q);                                              // R10
    AST_MEM_RETRY_FREE: assert property (@(posedge clk) disable iff (rst)
        mp_rsp_retry |-> (!ip_rsp_vld && !dp_rsp_vld));                    // R10

endmodule

// File: tb/blk_mem_fwd_tb.sv
module blk_mem_fwd_tb;
    import fwd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic                  ip_req_vld, ip_req_ifetch, ip_req_acc, ip_req_retry;
    logic [FWD_ADDR_W-1:0] ip_req_addr, ip_rsp_addr;
    logic [FWD_CMD_W-1:0]  ip_req_cmd, ip_rsp_cmd;
    logic [FWD_DATA_W-1:0] ip_req_data, ip_rsp_data;
    logic                  ip_rsp_vld, ip_rsp_ifetch, ip_rsp_acc, ip_rsp_retry;
    logic                  dp_req_vld, dp_req_ifetch, dp_req_acc, dp_req_retry;
    logic [FWD_ADDR_W-1:0] dp_req_addr, dp_rsp_addr;
    logic [FWD_CMD_W-1:0]  dp_req_cmd, dp_rsp_cmd;
    logic [FWD_DATA_W-1:0] dp_req_data, dp_rsp_data;
    logic                  dp_rsp_vld, dp_rsp_ifetch, dp_rsp_acc, dp_rsp_retry;
    logic                  mp_req_vld, mp_req_ifetch, mp_req_acc, mp_req_retry;
    logic [FWD_ADDR_W-1:0] mp_req_addr, mp_rsp_addr;
    logic [FWD_CMD_W-1:0]  mp_req_cmd, mp_rsp_cmd;
    logic [FWD_DATA_W-1:0] mp_req_data, mp_rsp_data;
    logic                  mp_rsp_vld, mp_rsp_ifetch, mp_rsp_acc, mp_rsp_retry;

    int n_run = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    blk_mem_fwd u_dut (
        .clk(clk), .rst(rst),
        .ip_req_vld(ip_req_vld), .ip_req_addr(ip_req_addr), .ip_req_cmd(ip_req_cmd),
        .ip_req_data(ip_req_data), .ip_req_ifetch(ip_req_ifetch), .ip_req_acc(ip_req_acc),
        .ip_req_retry(ip_req_retry), .ip_rsp_vld(ip_rsp_vld), .ip_rsp_addr(ip_rsp_addr),
        .ip_rsp_cmd(ip_rsp_cmd), .ip_rsp_data(ip_rsp_data), .ip_rsp_ifetch(ip_rsp_ifetch),
        .ip_rsp_acc(ip_rsp_acc), .ip_rsp_retry(ip_rsp_retry),
        .dp_req_vld(dp_req_vld), .dp_req_addr(dp_req_addr), .dp_req_cmd(dp_req_cmd),
        .dp_req_data(dp_req_data), .dp_req_ifetch(dp_req_ifetch), .dp_req_acc(dp_req_acc),
        .dp_req_retry(dp_req_retry), .dp_rsp_vld(dp_rsp_vld), .dp_rsp_addr(dp_rsp_addr),
        .dp_rsp_cmd(dp_rsp_cmd), .dp_rsp_data(dp_rsp_data), .dp_rsp_ifetch(dp_rsp_ifetch),
        .dp_rsp_acc(dp_rsp_acc), .dp_rsp_retry(dp_rsp_retry),
        .mp_req_vld(mp_req_vld), .mp_req_addr(mp_req_addr), .mp_req_cmd(mp_req_cmd),
        .mp_req_data(mp_req_data), .mp_req_ifetch(mp_req_ifetch), .mp_req_acc(mp_req_acc),
        .mp_req_retry(mp_req_retry), .mp_rsp_vld(mp_rsp_vld), .mp_rsp_addr(mp_rsp_addr),
        .mp_rsp_cmd(mp_rsp_cmd), .mp_rsp_data(mp_rsp_data), .mp_rsp_ifetch(mp_rsp_ifetch),
        .mp_rsp_acc(mp_rsp_acc), .mp_rsp_retry(mp_rsp_retry)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic drop();
        ip_req_vld = 0; dp_req_vld = 0; ip_rsp_acc = 0; dp_rsp_acc = 0;
        ip_rsp_retry = 0; dp_rsp_retry = 0; mp_req_acc = 0; mp_req_retry = 0;
        mp_rsp_vld = 0;
    endtask

    // Advance to just after the next falling edge and release all strobes.
    task automatic nxt();
        @(negedge clk);
        #1;
        drop();
    endtask

    task automatic offer(input bit dside, input logic [31:0] a, input logic [31:0] d, input bit fe);
        if (dside) begin
            dp_req_vld = 1; dp_req_addr = a; dp_req_data = d; dp_req_ifetch = fe; dp_req_cmd = 2'd1;
        end else begin
            ip_req_vld = 1; ip_req_addr = a; ip_req_data = d; ip_req_ifetch = fe; ip_req_cmd = 2'd1;
        end
        #1;
    endtask

    task automatic mem_reply(input bit fe, input logic [31:0] d);
        mp_rsp_vld = 1; mp_rsp_ifetch = fe; mp_rsp_data = d; mp_rsp_addr = '0; mp_rsp_cmd = 2'd2;
        #1;
    endtask

    task automatic t_reset();
        nxt(); #1;
        chk("R1 mp_req_vld", mp_req_vld, 0);
        chk("R1 ip_rsp_vld", ip_rsp_vld, 0);
        chk("R1 dp_rsp_vld", dp_rsp_vld, 0);
        chk("R1 retries", {ip_req_retry, dp_req_retry, mp_rsp_retry}, 0);
        chk("R1 accepts", {ip_req_acc, dp_req_acc, mp_rsp_acc}, 0);
    endtask

    task automatic t_basic_fetch();
        nxt(); offer(0, 32'h100, 32'hA5, 1);
        chk("R2 ip accept idle", ip_req_acc, 1);
        nxt(); mp_req_acc = 1; #1;
        chk("R2 forwarded valid", mp_req_vld, 1);
        chk("R2 forwarded addr", mp_req_addr, 32'h100);
        chk("R2 forwarded data", mp_req_data, 32'hA5);
        chk("R2 forwarded cmd", mp_req_cmd, 1);
        chk("R2 forwarded tag", mp_req_ifetch, 1);
        offer(1, 32'h200, 32'h0, 0);
        chk("R3 busy reject", dp_req_acc, 0);
        nxt(); #1;
        chk("R2 valid drops after take", mp_req_vld, 0);
        chk("R9 no retry while busy", dp_req_retry, 0);
        mem_reply(1, 32'hBEEF);
        chk("R6 mem rsp accept", mp_rsp_acc, 1);
        nxt(); ip_rsp_acc = 1; #1;
        chk("R6 fetch routed to ip", ip_rsp_vld, 1);
        chk("R6 fetch data", ip_rsp_data, 32'hBEEF);
        chk("R6 not to dp", dp_rsp_vld, 0);
        chk("R8 owed dp retry", dp_req_retry, 1);
        chk("R8 no ip retry", ip_req_retry, 0);
        nxt(); #1;
        chk("R8 retry single pulse", dp_req_retry, 0);
        chk("R6 ip rsp delivered once", ip_rsp_vld, 0);
    endtask

    task automatic t_data_route();
        nxt(); offer(1, 32'h200, 32'h11, 0);
        chk("R2 dp accept idle", dp_req_acc, 1);
        nxt(); mp_req_acc = 1; #1;
        chk("R2 dp forwarded tag", mp_req_ifetch, 0);
        chk("R2 dp forwarded addr", mp_req_addr, 32'h200);
        nxt(); mem_reply(0, 32'h22);
        chk("R6 mem rsp accept", mp_rsp_acc, 1);
        nxt(); dp_rsp_acc = 1; offer(0, 32'h300, 32'h0, 1);
        chk("R6 data routed to dp", dp_rsp_vld, 1);
        chk("R6 data value", dp_rsp_data, 32'h22);
        chk("R6 not to ip", ip_rsp_vld, 0);
        chk("R6 idle in delivery cycle", ip_req_acc, 1);
        nxt(); mp_req_acc = 1; #1;
        chk("R2 next forwarded", mp_req_addr, 32'h300);
        nxt(); mem_reply(1, 32'h33);
        nxt(); ip_rsp_acc = 1; #1;
        chk("R6 second fetch data", ip_rsp_data, 32'h33);
    endtask

    task automatic t_both_offer();
        nxt(); offer(0, 32'h400, 32'h0, 1); offer(1, 32'h500, 32'h0, 0);
        chk("R4 ip wins", ip_req_acc, 1);
        chk("R4 dp refused", dp_req_acc, 0);
        nxt(); mp_req_acc = 1; #1;
        chk("R4 winner forwarded", mp_req_addr, 32'h400);
        nxt(); mem_reply(1, 32'h44);
        nxt(); ip_rsp_acc = 1; #1;
        chk("R8 loser retried", dp_req_retry, 1);
        chk("R9 one port per cycle", ip_req_retry, 0);
        nxt(); #1;
        chk("R8 loser retry ends", dp_req_retry, 0);
    endtask

    task automatic t_mem_refuse();
        nxt(); offer(0, 32'h600, 32'h66, 1);
        nxt(); #1;
        chk("R5 offered first", mp_req_vld, 1);
        nxt(); #1;
        chk("R5 withdrawn after refusal", mp_req_vld, 0);
        nxt(); #1;
        chk("R5 still waiting", mp_req_vld, 0);
        mp_req_retry = 1;
        nxt(); mp_req_acc = 1; #1;
        chk("R5 reoffered after retry", mp_req_vld, 1);
        chk("R5 same addr", mp_req_addr, 32'h600);
        chk("R5 same data", mp_req_data, 32'h66);
        nxt(); #1;
        chk("R5 done after take", mp_req_vld, 0);
        mem_reply(1, 32'h77);
        nxt(); ip_rsp_acc = 1; #1;
        chk("R6 fetch after resend", ip_rsp_data, 32'h77);
    endtask

    task automatic t_up_refuse();
        nxt(); offer(1, 32'h700, 32'h0, 0);
        nxt(); mp_req_acc = 1;
        nxt(); mem_reply(0, 32'h88);
        nxt(); #1;
        chk("R7 first offer", dp_rsp_vld, 1);
        nxt(); #1;
        chk("R7 withdrawn", dp_rsp_vld, 0);
        nxt(); #1;
        chk("R7 waits for retry", dp_rsp_vld, 0);
        dp_rsp_retry = 1;
        nxt(); dp_rsp_acc = 1; #1;
        chk("R7 reoffered", dp_rsp_vld, 1);
        chk("R7 same data", dp_rsp_data, 32'h88);
        nxt(); #1;
        chk("R7 delivered", dp_rsp_vld, 0);
    endtask

    task automatic t_owed_while_holding();
        nxt(); offer(1, 32'h800, 32'h0, 0);
        nxt(); mp_req_acc = 1;
        nxt(); mem_reply(0, 32'h99);
        nxt();                                  // dp refuses its response
        nxt(); offer(0, 32'h900, 32'h0, 1);
        chk("R6 idle while dp holds", ip_req_acc, 1);
        nxt(); mp_req_acc = 1; offer(1, 32'hA00, 32'h0, 0);
        chk("R3 dp refused while busy", dp_req_acc, 0);
        nxt(); mem_reply(1, 32'hAA);
        nxt(); ip_rsp_acc = 1; #1;
        chk("R6 ip delivered", ip_rsp_data, 32'hAA);
        chk("R8 no retry while holding", dp_req_retry, 0);
        dp_rsp_retry = 1;
        nxt(); dp_rsp_acc = 1; #1;
        chk("R7 held rsp data", dp_rsp_data, 32'h99);
        chk("R8 no retry until drained", dp_req_retry, 0);
        nxt(); #1;
        chk("R8 retry after drain", dp_req_retry, 1);
        nxt(); #1;
        chk("R8 pulse ends", dp_req_retry, 0);
    endtask

    task automatic t_mem_rsp_held();
        nxt(); offer(1, 32'hB00, 32'h0, 0);
        nxt(); mp_req_acc = 1;
        nxt(); mem_reply(0, 32'h55);
        nxt();                                  // dp refuses, keeps 0x55
        nxt(); offer(1, 32'hC00, 32'h0, 0);
        chk("R2 dp issues while holding", dp_req_acc, 1);
        nxt(); mp_req_acc = 1;
        nxt(); mem_reply(0, 32'h66);
        chk("R10 rsp to holding port refused", mp_rsp_acc, 0);
        nxt(); offer(0, 32'hD00, 32'h0, 1);
        chk("R3 still busy", ip_req_acc, 0);
        chk("R10 no retry while held", mp_rsp_retry, 0);
        dp_rsp_retry = 1;
        nxt(); dp_rsp_acc = 1; #1;
        chk("R7 old rsp first", dp_rsp_data, 32'h55);
        chk("R10 no retry until drained", mp_rsp_retry, 0);
        nxt(); #1;
        chk("R10 mem retry after drain", mp_rsp_retry, 1);
        chk("R9 no ip retry while busy", ip_req_retry, 0);
        nxt(); #1;
        chk("R10 mem retry one pulse", mp_rsp_retry, 0);
        mem_reply(0, 32'h66);
        chk("R10 resent rsp accepted", mp_rsp_acc, 1);
        nxt(); dp_rsp_acc = 1; #1;
        chk("R6 new rsp delivered", dp_rsp_data, 32'h66);
        chk("R8 ip owed retry", ip_req_retry, 1);
        nxt();
    endtask

    initial begin
        drop();
        ip_req_addr = '0; ip_req_cmd = '0; ip_req_data = '0; ip_req_ifetch = 0;
        dp_req_addr = '0; dp_req_cmd = '0; dp_req_data = '0; dp_req_ifetch = 0;
        mp_rsp_addr = '0; mp_rsp_cmd = '0; mp_rsp_data = '0; mp_rsp_ifetch = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_basic_fetch();
        t_data_route();
        t_both_offer();
        t_mem_refuse();
        t_up_refuse();
        t_owed_while_holding();
        t_mem_rsp_held();
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule